// File: doc/BRIEF.md
# I2C Master Command and Residual Engine

This block is the host-side command front end of a byte-level I2C controller. The host writes a 32-bit command word and then feeds or drains an 8-entry byte FIFO. The engine turns each command into a sequence of byte operations on an abstract bus port: start with address, send byte, receive byte and stop. Bit-level waveform generation sits behind that port and is not part of this block.

Each accepted command loads two residual counters with its length. The bus-side counter drops by one for every byte moved on the bus. The host-side counter drops by one for every byte the host moves through the FIFO. A command is finished only when both counters are zero. Errors are sticky flags, and a synchronous reset clears them.

A mode input relaxes FIFO flow control. With pacing allowed, a host push into a full FIFO or a pop from an empty one is dropped without raising an error.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, cmd_done is 1. xfer_busy, all four error flags, fifo_count, fe_left, be_left and bus_req are 0.
- R2: The command word is laid out as follows: bit 31 start, bit 30 address phase, bit 29 read continuation (carried, no effect), bit 28 stop, bits 23:17 device address, bit 16 read (1) or write (0), bits 15:0 length. A command with bits 31, 30 and 28 clear and a length of zero sets err_invalid and changes nothing else. Error flags stay set until reset.
- R3: A command written while cmd_done is 0 sets err_invalid and is discarded.
- R4: An accepted command loads both fe_left and be_left with its length in the following cycle and clears cmd_done.
- R5: A command with the start bit raises bus_req with bus_op 0 (start), carrying the latched bus_addr and bus_rnw. A NACK on that operation sets err_nack and leaves xfer_busy at 0. An ACK sets xfer_busy. While bus_req is high and bus_ack is low, bus_req and bus_op hold.
- R6: During a write, host FIFO-register writes (host_wr_sel=1, byte in bits 7:0) are sent with bus_op 1 in push order. Each host push decrements be_left and each bus byte decrements fe_left.
- R7: During a read, each bus_op 2 byte is pushed into the FIFO and decrements fe_left. Host pops return the bytes in bus order on host_rd_data in the cycle after the pop, and each pop decrements be_left.
- R8: A FIFO push or pop while xfer_busy is 0, or against the latched direction, sets err_invalid and leaves fifo_count unchanged.
- R9: A host push into a full FIFO, or a pop from an empty one, sets err_overrun unless pace_allow is 1. In either case the access is dropped and be_left is unchanged.
- R10: A host FIFO transfer while be_left is 0 sets err_access. be_left stays at 0.
- R11: When both counters are zero, cmd_done rises. If the command had the stop bit, a stop (bus_op 3) is issued and xfer_busy clears. Without it, xfer_busy stays 1, and a later stop-only command of length 0 closes the bus.
- R12: A NACK on a sent data byte sets err_nack. It is followed at once by a stop request and clears both counters and the FIFO. The engine then returns to idle with cmd_done 1.
- R13: fifo_count always shows the FIFO occupancy, which never exceeds the FIFO depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 1 | 0 = command word, 1 = FIFO byte |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Host FIFO pop strobe |
| host_rd_data | output | 8 | Byte returned by the last pop |
| pace_allow | input | 1 | Suppress FIFO overrun errors |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | 7 | Latched device address |
| bus_rnw | output | 1 | Latched direction |
| bus_wdata | output | 8 | Byte to send |
| bus_ack | input | 1 | Operation finished (one-cycle pulse) |
| bus_nack | input | 1 | Target refused, valid with bus_ack |
| bus_rdata | input | 8 | Received byte, valid with bus_ack |
| cmd_done | output | 1 | Command complete |
| xfer_busy | output | 1 | Bus held by this engine |
| err_invalid | output | 1 | Sticky invalid-command flag |
| err_nack | output | 1 | Sticky NACK flag |
| err_overrun | output | 1 | Sticky FIFO overrun/underrun flag |
| err_access | output | 1 | Sticky host-count exhaustion flag |
| fifo_count | output | 4 | FIFO occupancy |
| fe_left | output | 16 | Bus-side residual |
| be_left | output | 16 | Host-side residual |

## Verification
The bench fills the FIFO against a stalled bus to check overrun with and without pacing. A design that counted the refused byte would show be_left one short, and a design that ignored the mode bit would raise or miss err_overrun. It forces NACKs both on the address and on a mid-transfer byte. An engine that kept sending, or never re-armed cmd_done, would be caught by the send count and the completion check. A command without stop followed by a stop-only command checks that completion and bus release are separate. Randomised write and read transfers with varying bus latency compare every byte against the order the bench produced.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_SEND  = 2'd1,
    BOP_RECV  = 2'd2,
    BOP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    XS_IDLE, XS_START, XS_RUN, XS_SEND, XS_RECV, XS_STOP
  } xfer_state_e;

  typedef struct packed {
    logic              start;
    logic              with_addr;
    logic              rd_cont;
    logic              stop;
    logic [3:0]        rsvd;
    logic [ADDR_W-1:0] dev;
    logic              rnw;
    logic [LEN_W-1:0]  len;
  } cmd_word_t;
endpackage

// File: rtl/i2c_eng_fifo.sv
module i2c_eng_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_eng_resid.sv
module i2c_eng_resid #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] val,
  output logic         zero,
  output logic         fault
);
  assign zero  = (val == '0);
  assign fault = dec && !load && zero;

  always_ff @(posedge clk) begin
    if (rst || clr)        val <= '0;
    else if (load)         val <= load_val;
    else if (dec && !zero) val <= val - 1'b1;
  end
endmodule

// File: rtl/i2c_eng_xfer.sv
module i2c_eng_xfer
  import i2c_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_start,
  input  logic              rnw,
  input  logic              stop_req,
  input  logic              fe_zero,
  input  logic              be_zero,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [BYTE_W-1:0] fifo_head,
  input  logic              bus_ack,
  input  logic              bus_nack,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              busy,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic              fe_dec,
  output logic              nack_evt,
  output logic              abort,
  output logic              settled
);
  xfer_state_e st;
  bus_op_e     op;

  always_comb begin
    unique case (st)
      XS_SEND: op = BOP_SEND;
      XS_RECV: op = BOP_RECV;
      XS_STOP: op = BOP_STOP;
      default: op = BOP_START;
    endcase
  end

  assign bus_op    = op;
  assign bus_req   = (st == XS_START) || (st == XS_SEND) ||
                     (st == XS_RECV)  || (st == XS_STOP);
  assign fifo_pop  = (st == XS_SEND) && bus_ack;
  assign fifo_push = (st == XS_RECV) && bus_ack;
  assign fe_dec    = ((st == XS_SEND) || (st == XS_RECV)) && bus_ack;
  assign nack_evt  = bus_ack && bus_nack && ((st == XS_START) || (st == XS_SEND));
  assign abort     = (st == XS_SEND) && bus_ack && bus_nack;
  assign settled   = fe_zero && be_zero &&
                     ((st == XS_IDLE) || ((st == XS_RUN) && !stop_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XS_IDLE;
      busy      <= 1'b0;
      bus_wdata <= '0;
    end else begin
      unique case (st)
        XS_IDLE: if (go_start) st <= XS_START;
        XS_START: if (bus_ack) begin
          if (bus_nack) begin
            st   <= XS_IDLE;
            busy <= 1'b0;
          end else begin
            st   <= XS_RUN;
            busy <= 1'b1;
          end
        end
        XS_RUN: begin
          if (go_start) st <= XS_START;
          else if (fe_zero && be_zero && stop_req) st <= XS_STOP;
          else if (!fe_zero && !rnw && !fifo_empty) begin
            st        <= XS_SEND;
            bus_wdata <= fifo_head;
          end
          else if (!fe_zero && rnw && !fifo_full) st <= XS_RECV;
        end
        XS_SEND: if (bus_ack) st <= bus_nack ? XS_STOP : XS_RUN;
        XS_RECV: if (bus_ack) st <= XS_RUN;
        XS_STOP: if (bus_ack) begin
          st   <= XS_IDLE;
          busy <= 1'b0;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_wr_sel,
  input  logic [31:0]       host_wr_data,
  input  logic              host_rd_en,
  output logic [BYTE_W-1:0] host_rd_data,
  input  logic              pace_allow,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_nack,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              cmd_done,
  output logic              xfer_busy,
  output logic              err_invalid,
  output logic              err_nack,
  output logic              err_overrun,
  output logic              err_access,
  output logic [CNT_W-1:0]  fifo_count,
  output logic [LEN_W-1:0]  fe_left,
  output logic [LEN_W-1:0]  be_left
);
  cmd_word_t cmd_in;
  logic cmd_wr, fifo_wr, fifo_rd, cmd_valid, accept, go_start;
  logic rnw_q, stop_q;
  logic [ADDR_W-1:0] dev_q;
  logic host_push, host_pop, inv_evt, ovr_evt;
  logic f_full, f_empty, f_push, f_pop;
  logic [BYTE_W-1:0] f_head, f_wdata;
  logic x_pop, x_push, x_fe_dec, x_nack, x_abort, x_settled;
  logic [LEN_W-1:0] rc_val [2];
  logic rc_zero [2];
  logic rc_fault [2];
  logic rc_dec [2];
  logic unused_bits;

  assign cmd_in    = cmd_word_t'(host_wr_data);
  assign cmd_wr    = host_wr_en && !host_wr_sel;
  assign fifo_wr   = host_wr_en && host_wr_sel;
  assign fifo_rd   = host_rd_en;
  assign cmd_valid = cmd_in.start || cmd_in.with_addr || cmd_in.stop || (cmd_in.len != '0);
  assign accept    = cmd_wr && cmd_valid && cmd_done;
  assign go_start  = accept && cmd_in.start;
  assign unused_bits = ^{cmd_in.rd_cont, cmd_in.rsvd, rc_fault[0]};

  assign host_push = fifo_wr && xfer_busy && !rnw_q && !f_full;
  assign host_pop  = fifo_rd && xfer_busy && rnw_q && !f_empty;
  assign inv_evt   = (cmd_wr && (!cmd_valid || !cmd_done)) ||
                     (fifo_wr && (!xfer_busy || rnw_q)) ||
                     (fifo_rd && (!xfer_busy || !rnw_q));
  assign ovr_evt   = !pace_allow &&
                     ((fifo_wr && xfer_busy && !rnw_q && f_full) ||
                      (fifo_rd && xfer_busy && rnw_q && f_empty));

  assign f_push  = host_push || x_push;
  assign f_pop   = host_pop || x_pop;
  assign f_wdata = rnw_q ? bus_rdata : host_wr_data[BYTE_W-1:0];

  assign rc_dec[0] = x_fe_dec;
  assign rc_dec[1] = host_push || host_pop;
  assign fe_left   = rc_val[0];
  assign be_left   = rc_val[1];
  assign bus_addr  = dev_q;
  assign bus_rnw   = rnw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rnw_q  <= 1'b0;
      stop_q <= 1'b0;
      dev_q  <= '0;
    end else if (accept) begin
      rnw_q  <= cmd_in.rnw;
      stop_q <= cmd_in.stop;
      dev_q  <= cmd_in.dev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_done     <= 1'b1;
      err_invalid  <= 1'b0;
      err_nack     <= 1'b0;
      err_overrun  <= 1'b0;
      err_access   <= 1'b0;
      host_rd_data <= '0;
    end else begin
      if (accept)         cmd_done <= 1'b0;
      else if (x_settled) cmd_done <= 1'b1;
      if (inv_evt)     err_invalid <= 1'b1;
      if (x_nack)      err_nack    <= 1'b1;
      if (ovr_evt)     err_overrun <= 1'b1;
      if (rc_fault[1]) err_access  <= 1'b1;
      if (host_pop)    host_rd_data <= f_head;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_resid
    i2c_eng_resid #(.W(LEN_W)) u_rc (
      .clk      (clk),
      .rst      (rst),
      .clr      (x_abort),
      .load     (accept),
      .load_val (cmd_in.len),
      .dec      (rc_dec[g]),
      .val      (rc_val[g]),
      .zero     (rc_zero[g]),
      .fault    (rc_fault[g])
    );
  end

  i2c_eng_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (x_abort),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .head  (f_head),
    .count (fifo_count),
    .full  (f_full),
    .empty (f_empty)
  );

  i2c_eng_xfer u_xfer (
    .clk        (clk),
    .rst        (rst),
    .go_start   (go_start),
    .rnw        (rnw_q),
    .stop_req   (stop_q),
    .fe_zero    (rc_zero[0]),
    .be_zero    (rc_zero[1]),
    .fifo_empty (f_empty),
    .fifo_full  (f_full),
    .fifo_head  (f_head),
    .bus_ack    (bus_ack),
    .bus_nack   (bus_nack),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_wdata  (bus_wdata),
    .busy       (xfer_busy),
    .fifo_pop   (x_pop),
    .fifo_push  (x_push),
    .fe_dec     (x_fe_dec),
    .nack_evt   (x_nack),
    .abort      (x_abort),
    .settled    (x_settled)
  );
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        host_wr_en,
  input logic        host_wr_sel,
  input logic [31:0] host_wr_data,
  input logic        cmd_done,
  input logic        bus_req,
  input logic [1:0]  bus_op,
  input logic        bus_ack,
  input logic        bus_nack,
  input logic        xfer_busy,
  input logic        err_invalid,
  input logic        err_nack,
  input logic [CNT_W-1:0] fifo_count,
  input logic [15:0] fe_left,
  input logic [15:0] be_left
);
  logic cmd_accept;
  assign cmd_accept = host_wr_en && !host_wr_sel && cmd_done &&
                      (host_wr_data[31] || host_wr_data[30] || host_wr_data[28] ||
                       (host_wr_data[15:0] != 16'd0));

  a_r2_sticky_invalid: assert property (@(posedge clk) disable iff (rst)
    err_invalid |=> err_invalid);

  a_r4_load_counters: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |=> (fe_left == $past(host_wr_data[15:0])) &&
                   (be_left == $past(host_wr_data[15:0])) && !cmd_done);

  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op)));

  a_r8_fifo_when_idle: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_wr_sel && !xfer_busy) |=> err_invalid);

  a_r12_stop_after_nack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && bus_nack && bus_op == 2'd1) |=>
      (bus_req && bus_op == 2'd3 && err_nack));

  a_r13_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wr_en   (host_wr_en),
  .host_wr_sel  (host_wr_sel),
  .host_wr_data (host_wr_data),
  .cmd_done     (cmd_done),
  .bus_req      (bus_req),
  .bus_op       (bus_op),
  .bus_ack      (bus_ack),
  .bus_nack     (bus_nack),
  .xfer_busy    (xfer_busy),
  .err_invalid  (err_invalid),
  .err_nack     (err_nack),
  .fifo_count   (fifo_count),
  .fe_left      (fe_left),
  .be_left      (be_left)
);

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr_en = 0, host_wr_sel = 0, host_rd_en = 0, pace_allow = 0;
  logic [31:0] host_wr_data = '0;
  logic [7:0] host_rd_data, bus_wdata;
  logic bus_req, bus_rnw, bus_ack = 0, bus_nack = 0;
  logic [1:0] bus_op;
  logic [6:0] bus_addr;
  logic [7:0] bus_rdata = '0;
  logic cmd_done, xfer_busy, err_invalid, err_nack, err_overrun, err_access;
  logic [CW-1:0] fifo_count;
  logic [15:0] fe_left, be_left;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int bus_dly = 0, nack_at = -1, cnt = 0;
  bit nack_addr = 0;
  int n_sent = 0, n_start = 0, n_stop = 0, n_recv = 0;
  logic [7:0] sent_log [64];
  logic [6:0] last_addr = '0;
  logic last_rnw = 0;
  logic [7:0] rx_seed = 8'h5A;

  always #10 clk = ~clk;

  i2c_cmd_engine #(.FIFO_DEPTH(DEPTH)) dut (.*);

  function automatic logic [7:0] rx_byte(input int i);
    return 8'((i * 37 + int'(rx_seed)) & 255);
  endfunction

  function automatic logic [31:0] mk_cmd(input bit st, input bit sp, input bit rd,
                                         input logic [6:0] a, input logic [15:0] n);
    return {st, st, 1'b0, sp, 4'b0, a, rd, n};
  endfunction

  // bus responder, acts on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 0; bus_nack = 0; cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 0; bus_nack = 0;
    end else if (bus_req) begin
      if (cnt >= bus_dly) begin
        cnt = 0; bus_ack = 1; bus_nack = 0;
        case (bus_op)
          2'd0: begin n_start++; last_addr = bus_addr; last_rnw = bus_rnw; bus_nack = nack_addr; end
          2'd1: begin sent_log[n_sent & 63] = bus_wdata; bus_nack = (n_sent == nack_at); n_sent++; end
          2'd2: begin bus_rdata = rx_byte(n_recv); n_recv++; end
          default: n_stop++;
        endcase
      end else cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_sent = 0; n_start = 0; n_stop = 0; n_recv = 0; nack_at = -1; nack_addr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; host_wr_en = 0; host_rd_en = 0;
    repeat (2) @(negedge clk);
    rst = 0; clear_log();
  endtask

  task automatic host_cmd(input logic [31:0] w);
    host_wr_en = 1; host_wr_sel = 0; host_wr_data = w;
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic host_push(input logic [7:0] b);
    host_wr_en = 1; host_wr_sel = 1; host_wr_data = {24'h0, b};
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic host_pop(output logic [7:0] b);
    host_rd_en = 1;
    @(negedge clk); host_rd_en = 0; b = host_rd_data;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 3000 && !xfer_busy; i++) @(negedge clk);
  endtask

  task automatic wait_done(input bit need_idle);
    for (int i = 0; i < 5000 && !(cmd_done && (!need_idle || !xfer_busy)); i++) @(negedge clk);
  endtask

  task automatic run_write(input int n, input logic [6:0] a);
    logic [7:0] exp [64];
    clear_log();
    host_cmd(mk_cmd(1, 1, 0, a, 16'(n)));
    wait_busy();
    chk("R5 start address", 32'(last_addr), 32'(a));
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3000 && fifo_count == CW'(DEPTH); k++) @(negedge clk);
      exp[i] = 8'($urandom);
      host_push(exp[i]);
    end
    wait_done(1);
    chk("R6 bytes sent", 32'(n_sent), 32'(n));
    for (int i = 0; i < n; i++) chk("R6 byte order", 32'(sent_log[i]), 32'(exp[i]));
    chk("R11 stop issued", 32'(n_stop), 32'd1);
    chk("R11 counters zero", {fe_left, be_left}, 32'd0);
  endtask

  task automatic run_read(input int n, input logic [6:0] a);
    logic [7:0] b;
    clear_log();
    rx_seed = 8'($urandom);
    host_cmd(mk_cmd(1, 1, 1, a, 16'(n)));
    wait_busy();
    chk("R5 read direction", 32'(last_rnw), 32'd1);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3000 && fifo_count == '0; k++) @(negedge clk);
      host_pop(b);
      chk("R7 read byte", 32'(b), 32'(rx_byte(i)));
    end
    wait_done(1);
    chk("R7 bytes received", 32'(n_recv), 32'(n));
    chk("R13 fifo drained", 32'(fifo_count), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b;
    void'($urandom(32'd1234));
    do_reset();
    // R1
    chk("R1 done", 32'(cmd_done), 1);
    chk("R1 busy/req", {30'd0, xfer_busy, bus_req}, 0);
    chk("R1 errors", {28'd0, err_invalid, err_nack, err_overrun, err_access}, 0);
    chk("R1 counts", {12'd0, fifo_count, fe_left}, 0);
    chk("R1 be", 32'(be_left), 0);

    // R2 empty command
    host_cmd(32'h2000_0000);
    @(negedge clk);
    chk("R2 invalid", 32'(err_invalid), 1);
    chk("R2 no start", 32'(n_start), 0);
    chk("R2 done kept", {cmd_done, fe_left}, {1'b1, 16'd0});

    // R4/R3 load and in-progress rejection
    do_reset(); bus_dly = 40;
    host_cmd(mk_cmd(1, 1, 0, 7'h2A, 16'd5));
    chk("R4 fe load", 32'(fe_left), 5);
    chk("R4 be load", 32'(be_left), 5);
    chk("R4 done cleared", 32'(cmd_done), 0);
    wait_busy();
    host_cmd(mk_cmd(1, 1, 0, 7'h11, 16'd3));
    chk("R3 invalid", 32'(err_invalid), 1);
    chk("R3 counters kept", {fe_left, be_left}, {16'd5, 16'd5});
    for (int i = 0; i < 5; i++) host_push(8'(8'hA0 + i));
    wait_done(1);
    chk("R6 sent", 32'(n_sent), 5);
    chk("R6 last byte", 32'(sent_log[4]), 32'hA4);

    // R9 overrun without pacing
    do_reset(); bus_dly = 200; pace_allow = 0;
    host_cmd(mk_cmd(1, 1, 0, 7'h10, 16'd12));
    wait_busy();
    for (int i = 0; i < 9; i++) host_push(8'(i));
    chk("R9 overrun", 32'(err_overrun), 1);
    chk("R13 full count", 32'(fifo_count), DEPTH);
    chk("R9 be unchanged by refused push", 32'(be_left), 4);

    // R9 with pacing
    do_reset(); bus_dly = 200; pace_allow = 1;
    host_cmd(mk_cmd(1, 1, 0, 7'h10, 16'd12));
    wait_busy();
    for (int i = 0; i < 9; i++) host_push(8'(i));
    chk("R9 paced no error", 32'(err_overrun), 0);
    chk("R9 paced be", 32'(be_left), 4);
    pace_allow = 0;

    // R9 empty pop during read
    do_reset(); bus_dly = 200;
    host_cmd(mk_cmd(1, 1, 1, 7'h12, 16'd2));
    wait_busy();
    host_pop(b);
    chk("R9 underrun", 32'(err_overrun), 1);
    chk("R9 underrun be", 32'(be_left), 2);

    // R10 access error
    do_reset(); bus_dly = 200;
    host_cmd(mk_cmd(1, 1, 0, 7'h13, 16'd1));
    wait_busy();
    host_push(8'h01);
    chk("R10 no error yet", 32'(err_access), 0);
    host_push(8'h02);
    chk("R10 access error", 32'(err_access), 1);
    chk("R10 be held", 32'(be_left), 0);

    // R8 wrong-state FIFO accesses
    do_reset();
    host_push(8'h55);
    chk("R8 push idle", {err_invalid, 3'd0, 4'(fifo_count)}, 8'h80);
    do_reset(); bus_dly = 200;
    host_cmd(mk_cmd(1, 1, 0, 7'h14, 16'd2));
    wait_busy();
    host_pop(b);
    chk("R8 pop in write", 32'(err_invalid), 1);
    chk("R8 count kept", 32'(fifo_count), 0);

    // R5 address NACK
    do_reset(); bus_dly = 1; nack_addr = 1;
    host_cmd(mk_cmd(1, 1, 0, 7'h15, 16'd2));
    repeat (8) @(negedge clk);
    chk("R5 nack flag", 32'(err_nack), 1);
    chk("R5 not busy", {xfer_busy, 7'd0, 8'(n_sent)}, 0);

    // R12 data NACK
    do_reset(); bus_dly = 2; nack_at = 1;
    host_cmd(mk_cmd(1, 1, 0, 7'h16, 16'd4));
    wait_busy();
    for (int i = 0; i < 4; i++) if (xfer_busy) host_push(8'(8'hC0 + i));
    wait_done(1);
    chk("R12 nack flag", 32'(err_nack), 1);
    chk("R12 sends stopped", 32'(n_sent), 2);
    chk("R12 stop issued", 32'(n_stop), 1);
    chk("R12 cleared", {fe_left, 12'd0, 4'(fifo_count)}, 0);

    // R11 no stop, then stop-only command
    do_reset(); bus_dly = 1;
    host_cmd(mk_cmd(1, 0, 0, 7'h17, 16'd2));
    wait_busy();
    host_push(8'h31); host_push(8'h32);
    wait_done(0);
    repeat (4) @(negedge clk);
    chk("R11 bus held", {cmd_done, xfer_busy}, 2'b11);
    chk("R11 no stop", 32'(n_stop), 0);
    host_cmd(mk_cmd(0, 1, 0, 7'h0, 16'd0));
    wait_done(1);
    chk("R11 stop-only", {8'(n_stop), 8'(n_start), 7'd0, xfer_busy}, {8'd1, 8'd1, 8'd0});

    // random traffic
    do_reset();
    for (int t = 0; t < 16; t++) begin
      bus_dly = $urandom_range(0, 3);
      if (t % 2 == 0) run_write($urandom_range(1, 20), 7'($urandom));
      else            run_read($urandom_range(1, 20), 7'($urandom));
    end
    chk("R9 no spurious errors", {err_invalid, err_nack, err_overrun, err_access}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule